// File: doc/BRIEF.md
# Programmable Envelope Generator

This block produces a 4-bit amplitude that rises or falls one step at a time, for use as the level of any sound channel. Two controls shape it: a 16-bit period that sets how long each step lasts, and a 4-bit shape code. The shape code chooses the starting direction, whether the ramp repeats, whether it turns round at each end, and whether it stops at a fixed value. Every ramp is 16 steps long. One step lasts 16 × period master clocks, so one full 16-step ramp runs at the master clock divided by 256 × period.

A strobe marks each write of the shape code. The block captures the code on that strobe and starts a new ramp at its first step. A change on the shape input without the strobe has no effect. The period input is used live. A period of zero acts as a period of one.

Top module: `envgen`

## Requirements
- R1: After reset, and until the first shape strobe, `level` is 0, whatever the shape input holds.
- R2: `level` shows the first step in the cycle after the clock edge that samples `shape_wr`. It moves to the next step exactly 16 × period clock edges after that edge, and again every 16 × period edges after that.
- R3: The shape code bits are: bit 3 continue, bit 2 attack, bit 1 alternate, bit 0 hold. In the first ramp, attack = 1 counts 0 up to 15 one per step, and attack = 0 counts 15 down to 0.
- R4: With continue = 0, `level` is 0 from the end of the first ramp onwards, whatever the alternate and hold bits are.
- R5: With continue = 1 and hold = 1, `level` stops after the first ramp. It stays at the ramp's final value when alternate = 0, and at the opposite extreme (0 ↔ 15) when alternate = 1.
- R6: With continue = 1, hold = 0 and alternate = 0, the ramp repeats in the same direction with no end.
- R7: With continue = 1, hold = 0 and alternate = 1, the ramp reverses direction after every 16 steps.
- R8: A period of 0 gives the same step timing as a period of 1 (16 clocks per step).
- R9: A shape strobe restarts the ramp from its first step with the new code. This holds in the middle of a ramp and after the block has stopped.
- R10: A change of the shape input while `shape_wr` is low changes neither the running ramp nor how it ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period | input | 16 | Step period multiplier (0 acts as 1) |
| shape | input | 4 | Shape code: continue, attack, alternate, hold (bits 3..0) |
| shape_wr | input | 1 | Shape write strobe; captures `shape` and restarts the ramp |
| level | output | 4 | Current envelope amplitude |

## Verification
The bench runs all sixteen shape codes over three full ramps each, with the level compared at every clock. Each group of codes therefore separates from the others by its behaviour after the first ramp: falling to zero, holding at 15 or at 0, wrapping, or turning round. Further runs use a period of 3 and a period of 0, which shows that the step length scales with the period and that zero acts as one. A strobe in the middle of a ramp, strobes after a frozen end, and a shape input flipped without a strobe show that only the strobe restarts the ramp or changes its ending.

// File: rtl/envgen_pkg.sv
package envgen_pkg;

  // Positions of the control bits inside the shape code
  localparam int SHAPE_W   = 4;
  localparam int BIT_CONT  = 3;
  localparam int BIT_ATT   = 2;
  localparam int BIT_ALT   = 1;
  localparam int BIT_HOLD  = 0;

  // The part of the shape code that matters once a ramp ends
  typedef struct packed {
    logic cont;
    logic alt;
    logic hold;
  } env_ctl_t;

  typedef enum logic [1:0] {
    END_ZERO   = 2'd0,
    END_FREEZE = 2'd1,
    END_WRAP   = 2'd2
  } end_act_t;

  function automatic env_ctl_t decode_ctl(input logic [SHAPE_W-1:0] code);
    env_ctl_t c;
    c.cont = code[BIT_CONT];
    c.alt  = code[BIT_ALT];
    c.hold = code[BIT_HOLD];
    return c;
  endfunction

  function automatic end_act_t end_action(input env_ctl_t c);
    if (!c.cont)     return END_ZERO;
    else if (c.hold) return END_FREEZE;
    else             return END_WRAP;
  endfunction

endpackage

// File: rtl/envgen_prescale.sv
module envgen_prescale #(
  parameter int PRE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic pre_tick
);

  logic [PRE_W-1:0] cnt;

  assign pre_tick = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + PRE_W'(1);
  end

endmodule

// File: rtl/envgen_period_div.sv
module envgen_period_div #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                pre_tick,
  input  logic [PERIOD_W-1:0] period,
  output logic                step_tick
);

  // A zero period behaves as one
  function automatic logic [PERIOD_W-1:0] eff_period(input logic [PERIOD_W-1:0] p);
    return (p == '0) ? PERIOD_W'(1) : p;
  endfunction

  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-1:0] last;

  assign last      = eff_period(period) - PERIOD_W'(1);
  // ">=" keeps a shrinking period from running the counter past its end
  assign step_tick = pre_tick && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clear)    cnt <= '0;
    else if (pre_tick) cnt <= step_tick ? '0 : cnt + PERIOD_W'(1);
  end

endmodule

// File: rtl/envgen_ramp.sv
module envgen_ramp
  import envgen_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_att,
  input  env_ctl_t          ctl,
  input  logic              step,
  output logic [STEP_W-1:0] pos,
  output logic              dir_up,
  output logic              frozen,
  output logic              hold_hi
);

  localparam logic [STEP_W-1:0] POS_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      dir_up  <= 1'b0;
      frozen  <= 1'b1;
      hold_hi <= 1'b0;
    end else if (start) begin
      pos     <= '0;
      dir_up  <= start_att;
      frozen  <= 1'b0;
      hold_hi <= 1'b0;
    end else if (step && !frozen) begin
      if (pos != POS_MAX) begin
        pos <= pos + STEP_W'(1);
      end else begin
        case (end_action(ctl))
          END_ZERO: begin
            frozen  <= 1'b1;
            hold_hi <= 1'b0;
          end
          END_FREEZE: begin
            frozen  <= 1'b1;
            hold_hi <= dir_up ^ ctl.alt;
          end
          default: begin
            pos    <= '0;
            dir_up <= dir_up ^ ctl.alt;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/envgen.sv
module envgen
  import envgen_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int PRE_W    = 4,
  parameter int LEVEL_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period,
  input  logic [SHAPE_W-1:0]  shape,
  input  logic                shape_wr,
  output logic [LEVEL_W-1:0]  level
);

  // Named internal events, also watched by the checker
  logic               pre_tick;
  logic               step_tick;
  logic [LEVEL_W-1:0] pos;
  logic               dir_up;
  logic               frozen;
  logic               hold_hi;
  env_ctl_t           ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctl_q <= '0;
    else if (shape_wr) ctl_q <= decode_ctl(shape);
  end

  envgen_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (shape_wr),
    .pre_tick (pre_tick)
  );

  envgen_period_div #(.PERIOD_W(PERIOD_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (shape_wr),
    .pre_tick  (pre_tick),
    .period    (period),
    .step_tick (step_tick)
  );

  envgen_ramp #(.STEP_W(LEVEL_W)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (shape_wr),
    .start_att (shape[BIT_ATT]),
    .ctl       (ctl_q),
    .step      (step_tick),
    .pos       (pos),
    .dir_up    (dir_up),
    .frozen    (frozen),
    .hold_hi   (hold_hi)
  );

  assign level = frozen ? {LEVEL_W{hold_hi}} : (dir_up ? pos : ~pos);

endmodule

// File: rtl/envgen_chk.sv
module envgen_chk
  import envgen_pkg::*;
#(
  parameter int LEVEL_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SHAPE_W-1:0] shape,
  input logic               shape_wr,
  input logic [LEVEL_W-1:0] level,
  input logic               step_tick,
  input logic               frozen,
  input env_ctl_t           ctl_q
);

  localparam logic [LEVEL_W-1:0] LVL_TOP = '1;

  logic seen_wr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_wr <= 1'b0;
    else if (shape_wr) seen_wr <= 1'b1;
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_wr |-> level == '0);                                             // R1

  AST_STEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_tick && !shape_wr) |=> $stable(level));                         // R2

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_tick && !frozen && !shape_wr && level != '0 && level != LVL_TOP)
    |=> (level == LEVEL_W'($past(level) + 1'b1)) ||
        (level == LEVEL_W'($past(level) - 1'b1)));                         // R3

  AST_CONT_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !ctl_q.cont) |-> level == '0);                              // R4

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !shape_wr) |=> $stable(level));                             // R5

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    shape_wr |=> level == ($past(shape[BIT_ATT]) ? '0 : LVL_TOP));         // R9

endmodule

bind envgen envgen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shape     (shape),
  .shape_wr  (shape_wr),
  .level     (level),
  .step_tick (step_tick),
  .frozen    (frozen),
  .ctl_q     (ctl_q)
);

// File: tb/envgen_test.sv
`timescale 1ns/1ps
module envgen_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] period;
  logic [3:0]  shape;
  logic        shape_wr;
  logic [3:0]  level;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  envgen uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .period   (period),
    .shape    (shape),
    .shape_wr (shape_wr),
    .level    (level)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: level=%0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Model restated from the requirements: bit3 continue, bit2 attack, bit1 alternate, bit0 hold
  function automatic int ramp_val(input bit up, input int i);
    return up ? i : 15 - i;
  endfunction

  function automatic int exp_lvl(input logic [3:0] s, input int k);
    int  c   = k / 16;
    int  i   = k % 16;
    bit  att = s[2];
    if (c == 0)  return ramp_val(att, i);       // R3
    if (!s[3])   return 0;                      // R4
    if (s[0])    return (att ^ s[1]) ? 15 : 0;  // R5
    if (s[1] && (c % 2 == 1)) return ramp_val(!att, i); // R7
    return ramp_val(att, i);                    // R6
  endfunction

  function automatic string req_of(input logic [3:0] s, input int k);
    if (k < 16)  return "R3";
    if (!s[3])   return "R4";
    if (s[0])    return "R5";
    if (s[1])    return "R7";
    return "R6";
  endfunction

  task automatic write_shape(input logic [3:0] s, input logic [15:0] ep);
    @(negedge clk);
    period   = ep;
    shape    = s;
    shape_wr = 1'b1;
    @(negedge clk);
    shape_wr = 1'b0;
    shape    = ~s;      // R10: flipped input without strobe must be ignored
  endtask

  // Writes a code, then compares the level at every negedge (R2 step timing)
  task automatic run_shape(input logic [3:0] s, input logic [15:0] ep,
                           input int steps, input string tag);
    int eff = (ep == 0) ? 1 : int'(ep);
    int len = 16 * eff;
    write_shape(s, ep);
    for (int n = 0; n < steps * len; n++) begin
      check($sformatf("%s/%s shape=%b n=%0d", tag, req_of(s, n / len), s, n),
            int'(level), exp_lvl(s, n / len));
      @(negedge clk);
    end
  endtask

  task automatic test_reset;
    rst_n    = 1'b0;
    shape_wr = 1'b0;
    shape    = 4'b1101;
    period   = 16'd1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", int'(level), 0);
    rst_n = 1'b1;
    for (int n = 0; n < 64; n++) begin
      @(negedge clk);
      check("R1 idle after reset", int'(level), 0);
    end
  endtask

  task automatic test_all_shapes;
    for (int s = 0; s < 16; s++) run_shape(4'(s), 16'd1, 48, "R2");
  endtask

  task automatic test_period;
    run_shape(4'b1100, 16'd3, 20, "R2 period3");
    run_shape(4'b1110, 16'd0, 34, "R8 period0");
  endtask

  task automatic test_restart;
    run_shape(4'b1000, 16'd1, 5, "R9 before");
    run_shape(4'b1111, 16'd1, 40, "R9 midramp");
    run_shape(4'b0100, 16'd1, 20, "R9 afterhold");
  endtask

  task automatic test_ignore;
    run_shape(4'b1010, 16'd2, 20, "R10");
  endtask

  initial begin
    test_reset();
    test_all_shapes();
    test_period();
    test_restart();
    test_ignore();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule